// File: doc/BRIEF.md
# Dual-Plane Blinking LED Scan Controller

This block drives a multiplexed LED display of up to eight digits, each with eight segment bits. Each digit has one byte in each of two planes, a low plane and a high plane. A segment's pair of bits, one from each plane, says whether it stays dark, stays lit, or lights in only one half of a repeating blink period. A host writes plane bytes through a simple write port. The block then scans the digits one at a time. Within each digit's slot it applies a sixteen-step PWM brightness duty. A frame counter flips the blink phase after a programmable number of complete scan frames.

The scan advances only on a tick input. Each digit slot lasts sixteen ticks. A digit's byte pair is latched at the start of its slot. A write therefore appears from that digit's next slot onward. Shutdown darkens every output. The plane contents are kept and the scan keeps running.

Top module: `led_blink_scan`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` at digit `wr_addr` of the plane picked by `wr_plane` (0 = low plane, 1 = high plane). The byte is shown from that digit's next slot start. A write in the same cycle as that digit's slot load is shown one frame later.
- R2: With `blink_en` low, segment bit b of the active digit is lit exactly when bit b of its low-plane byte is 1. The high-plane bit has no effect.
- R3: With `blink_en` high, a segment's pair (high bit, low bit) behaves as follows: 00 is dark for the whole blink period, 01 is lit only in the first half, 10 is lit only in the second half, and 11 is lit in both halves.
- R4: While not shut down, `digit_en` has exactly one bit set, bit i for the digit i being scanned.
- R5: Digits are scanned in the order 0, 1, … up to `scan_limit`, then back to 0. If the current digit is at or above `scan_limit` when its slot ends, the next digit is 0.
- R6: A slot lasts 16 ticks, numbered 0 to 15. Segments may be lit only in ticks whose number is below min(`intensity`+1, 15). In every other tick of the slot they are forced to 0.
- R7: While blink is enabled, the blink phase flips each time `blink_frames` complete frames have been scanned. A frame is complete when the scan wraps to digit 0. A value of 0 acts as 1.
- R8: While `blink_en` is low, the phase is held at the first half and the frame count is cleared. After enabling, the scan therefore starts in the first half.
- R9: With `shutdown` high, `digit_en` and `seg_out` are 0 on the next clock. The plane contents and the scan state are kept.
- R10: The outputs are registered and reflect the state one clock earlier. After reset both outputs are 0, and the scan starts at digit 0, tick 0, first half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Scan advance enable |
| wr_en | input | 1 | Plane write strobe |
| wr_plane | input | 1 | Plane select: 0 low, 1 high |
| wr_addr | input | 3 | Digit index of the write |
| wr_data | input | 8 | Segment byte written |
| blink_en | input | 1 | Global blink enable |
| intensity | input | 4 | PWM brightness code |
| scan_limit | input | 3 | Highest digit index scanned |
| blink_frames | input | 8 | Frames per blink half |
| shutdown | input | 1 | Forces all outputs inactive |
| digit_en | output | 8 | One-hot digit select |
| seg_out | output | 8 | Segment drive, 1 = lit |

## Verification
The hardest coincidence is a slot boundary that lands on the scan wrap. In the same tick the frame count can expire and flip the blink phase, and a host write can hit the digit whose byte pair is being latched. The bench provokes this by writing continuously to changing addresses while the scan runs with a blink period of one or two frames. It also lowers the scan limit mid-frame and toggles blink and shutdown at arbitrary points. A behavioural model, which reads old data on a same-address load and flips phase on the wrap, predicts both outputs, and they are compared on every clock.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;
  localparam int unsigned PLANES = 2;

  // PWM on-window length for a brightness code, capped one step below the slot length
  function automatic int unsigned on_window(input int unsigned code, input int unsigned steps);
    int unsigned w;
    w = code + 1;
    if (w > steps - 1) w = steps - 1;
    return w;
  endfunction
endpackage

// File: rtl/led_plane_store.sv
module led_plane_store #(
  parameter int DIGITS = 8,
  parameter int SEG_W  = 8,
  localparam int DIG_W = $clog2(DIGITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_plane,
  input  logic [DIG_W-1:0] wr_addr,
  input  logic [SEG_W-1:0] wr_data,
  input  logic             rd_en,
  input  logic [DIG_W-1:0] rd_addr,
  output logic [SEG_W-1:0] rd_lo,
  output logic [SEG_W-1:0] rd_hi
);
  import led_scan_pkg::*;

  for (genvar p = 0; p < PLANES; p++) begin : g_plane
    logic [SEG_W-1:0] mem [DIGITS];
    logic [SEG_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (wr_en && (wr_plane == p[0])) mem[wr_addr] <= wr_data;
    end

    // read-first synchronous port: the byte latched for a slot
    always_ff @(posedge clk) begin
      if (rst) rd_q <= '0;
      else if (rd_en) rd_q <= mem[rd_addr];
    end
  end

  assign rd_lo = g_plane[0].rd_q;
  assign rd_hi = g_plane[1].rd_q;
endmodule

// File: rtl/led_scan_timer.sv
module led_scan_timer #(
  parameter int DIGITS  = 8,
  parameter int INT_W   = 4,
  parameter int FRAME_W = 8,
  localparam int DIG_W  = $clog2(DIGITS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic [DIG_W-1:0]   scan_limit,
  input  logic               blink_en,
  input  logic [FRAME_W-1:0] blink_frames,
  output logic [INT_W-1:0]   pwm_cnt,
  output logic [DIG_W-1:0]   digit,
  output logic               phase,
  output logic               load,
  output logic [DIG_W-1:0]   next_digit
);
  logic [FRAME_W-1:0] frame_cnt;
  logic [FRAME_W:0]   frame_lim;
  logic               wrap;

  assign load       = tick && (&pwm_cnt);
  assign wrap       = digit >= scan_limit;
  assign next_digit = wrap ? '0 : digit + 1'b1;
  assign frame_lim  = (blink_frames == '0) ? {{FRAME_W{1'b0}}, 1'b1} : {1'b0, blink_frames};

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_cnt <= '0;
      digit   <= '0;
    end else if (tick) begin
      pwm_cnt <= pwm_cnt + 1'b1;
      if (load) digit <= next_digit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !blink_en) begin
      frame_cnt <= '0;
      phase     <= 1'b0;
    end else if (load && wrap) begin
      if ({1'b0, frame_cnt} + 1'b1 >= frame_lim) begin
        frame_cnt <= '0;
        phase     <= ~phase;
      end else begin
        frame_cnt <= frame_cnt + 1'b1;
      end
    end
  end

  // R5: a slot ending at or beyond the limit returns the scan to digit 0
  a_r5_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    (load && (digit >= scan_limit)) |=> (digit == '0));

  // R8: with blink off the phase sits in the first half
  a_r8_phase_held: assert property (@(posedge clk) disable iff (rst)
    !blink_en |=> !phase);

  // R7: the phase only moves on a frame wrap
  a_r7_phase_on_wrap: assert property (@(posedge clk) disable iff (rst)
    (blink_en && !(load && (digit >= scan_limit))) |=> $stable(phase));
endmodule

// File: rtl/led_seg_mixer.sv
module led_seg_mixer #(
  parameter int DIGITS = 8,
  parameter int SEG_W  = 8,
  parameter int INT_W  = 4,
  localparam int DIG_W = $clog2(DIGITS),
  localparam int STEPS = 1 << INT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [INT_W-1:0]  pwm_cnt,
  input  logic [DIG_W-1:0]  digit,
  input  logic              phase,
  input  logic [SEG_W-1:0]  slot_lo,
  input  logic [SEG_W-1:0]  slot_hi,
  input  logic              blink_en,
  input  logic [INT_W-1:0]  intensity,
  input  logic              shutdown,
  output logic [DIGITS-1:0] digit_en,
  output logic [SEG_W-1:0]  seg_out
);
  import led_scan_pkg::*;

  logic [DIGITS-1:0] dig_dec;
  logic [INT_W:0]    window;
  logic              lit_now;
  logic [SEG_W-1:0]  pick;

  for (genvar i = 0; i < DIGITS; i++) begin : g_dec
    assign dig_dec[i] = (digit == i[DIG_W-1:0]);
  end

  assign window  = (INT_W+1)'(on_window(int'(intensity), STEPS));
  assign lit_now = {1'b0, pwm_cnt} < window;
  assign pick    = (blink_en && phase) ? slot_hi : slot_lo;

  always_ff @(posedge clk) begin
    if (rst || shutdown) begin
      digit_en <= '0;
      seg_out  <= '0;
    end else begin
      digit_en <= dig_dec;
      seg_out  <= lit_now ? pick : '0;
    end
  end

  // R4: never more than one digit selected
  a_r4_one_digit: assert property (@(posedge clk) disable iff (rst)
    $onehot0(digit_en));

  // R9: shutdown darkens both outputs on the next clock
  a_r9_shutdown_dark: assert property (@(posedge clk) disable iff (rst)
    shutdown |=> (digit_en == '0 && seg_out == '0));

  // R6: the last tick of each slot is always dark
  a_r6_last_tick_dark: assert property (@(posedge clk) disable iff (rst)
    (&pwm_cnt) |=> (seg_out == '0));

  // R2: with blink off the high plane is not consulted
  a_r2_low_plane_only: assert property (@(posedge clk) disable iff (rst)
    (!blink_en && !shutdown && lit_now) |=> (seg_out == $past(slot_lo)));
endmodule

// File: rtl/led_blink_scan.sv
module led_blink_scan #(
  parameter int DIGITS  = 8,
  parameter int SEG_W   = 8,
  parameter int INT_W   = 4,
  parameter int FRAME_W = 8,
  localparam int DIG_W  = $clog2(DIGITS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               wr_en,
  input  logic               wr_plane,
  input  logic [DIG_W-1:0]   wr_addr,
  input  logic [SEG_W-1:0]   wr_data,
  input  logic               blink_en,
  input  logic [INT_W-1:0]   intensity,
  input  logic [DIG_W-1:0]   scan_limit,
  input  logic [FRAME_W-1:0] blink_frames,
  input  logic               shutdown,
  output logic [DIGITS-1:0]  digit_en,
  output logic [SEG_W-1:0]   seg_out
);
  logic [INT_W-1:0] pwm_cnt;
  logic [DIG_W-1:0] digit, next_digit;
  logic             phase, load;
  logic [SEG_W-1:0] slot_lo, slot_hi;

  led_scan_timer #(.DIGITS(DIGITS), .INT_W(INT_W), .FRAME_W(FRAME_W)) u_timer (
    .clk, .rst, .tick, .scan_limit, .blink_en, .blink_frames,
    .pwm_cnt, .digit, .phase, .load, .next_digit
  );

  led_plane_store #(.DIGITS(DIGITS), .SEG_W(SEG_W)) u_store (
    .clk, .rst, .wr_en, .wr_plane, .wr_addr, .wr_data,
    .rd_en(load), .rd_addr(next_digit), .rd_lo(slot_lo), .rd_hi(slot_hi)
  );

  led_seg_mixer #(.DIGITS(DIGITS), .SEG_W(SEG_W), .INT_W(INT_W)) u_mix (
    .clk, .rst, .pwm_cnt, .digit, .phase, .slot_lo, .slot_hi,
    .blink_en, .intensity, .shutdown, .digit_en, .seg_out
  );
endmodule

// File: tb/tb_led_blink_scan.sv
module tb_led_blink_scan;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0, wr_en = 1'b0, wr_plane = 1'b0;
  logic [2:0] wr_addr = '0, scan_limit = 3'd7;
  logic [7:0] wr_data = '0, blink_frames = 8'd1;
  logic       blink_en = 1'b0, shutdown = 1'b0;
  logic [3:0] intensity = 4'd15;
  logic [7:0] digit_en, seg_out;

  led_blink_scan dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0, n_fail = 0;
  string tag = "R10";

  // behavioural reference state
  int m_tick, m_dig, m_frame, m_half;
  logic [7:0] m_lo [8], m_hi [8];
  logic [7:0] m_slo, m_shi, exp_dig, exp_seg;

  always @(posedge clk) begin
    if (rst) begin
      m_tick = 0; m_dig = 0; m_frame = 0; m_half = 0;
      m_slo = 0; m_shi = 0; exp_dig = 0; exp_seg = 0;
    end else begin
      int win, nxt, lim;
      win = intensity + 1; if (win > 15) win = 15;
      exp_dig = shutdown ? 8'h00 : 8'(1 << m_dig);
      if (shutdown || m_tick >= win) exp_seg = 0;
      else exp_seg = (blink_en && m_half == 1) ? m_shi : m_slo;
      if (tick) begin
        if (m_tick == 15) begin
          nxt = (m_dig >= int'(scan_limit)) ? 0 : m_dig + 1;
          m_slo = m_lo[nxt]; m_shi = m_hi[nxt];
          if (nxt == 0 && m_dig >= int'(scan_limit) && blink_en) begin
            lim = (blink_frames == 0) ? 1 : int'(blink_frames);
            m_frame++;
            if (m_frame >= lim) begin m_frame = 0; m_half = 1 - m_half; end
          end
          m_dig = nxt;
        end
        m_tick = (m_tick + 1) % 16;
      end
      if (!blink_en) begin m_half = 0; m_frame = 0; end
      if (wr_en) begin
        if (wr_plane) m_hi[wr_addr] = wr_data; else m_lo[wr_addr] = wr_data;
      end
    end
  end

  always @(negedge clk) begin
    n_checks++;
    if (digit_en !== exp_dig || seg_out !== exp_seg) begin
      n_fail++;
      $display("FAIL %s t=%0t digit_en=%h exp %h seg_out=%h exp %h",
               tag, $time, digit_en, exp_dig, seg_out, exp_seg);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put(input logic pl, input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_plane = pl; wr_addr = 3'(a); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  bit done = 0;
  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    step(4);
    rst = 0;
    step(3);
    // R1: fill both planes with distinct patterns (P1,P0 pairs mixed)
    tag = "R1";
    for (int i = 0; i < 8; i++) begin
      put(0, i, 8'(8'hA5 ^ (i * 8'h13)));
      put(1, i, 8'(8'h3C ^ (i * 8'h29)));
    end
    // R2, R4: blink off, full brightness, full scan
    tag = "R2"; tick = 1; step(300);
    tag = "R4"; step(100);
    // R6: reduced brightness with gapped ticks, several codes
    tag = "R6";
    for (int k = 0; k < 16; k += 5) begin
      intensity = 4'(k);
      for (int c = 0; c < 120; c++) begin tick = (c % 3 != 0); step(1); end
    end
    intensity = 4'd14; tick = 1; step(80);
    // R5: short scan, then lower the limit mid-frame
    tag = "R5"; scan_limit = 3'd3; step(200);
    scan_limit = 3'd5; step(70);
    scan_limit = 3'd1; step(150);
    scan_limit = 3'd0; step(60);
    scan_limit = 3'd7;
    // R3, R7: blink on with one and two frames per half, and 0 acting as 1
    tag = "R3"; intensity = 4'd15; blink_en = 1; blink_frames = 8'd1; step(700);
    tag = "R7"; blink_frames = 8'd2; step(900);
    blink_frames = 8'd0; scan_limit = 3'd2; step(400);
    scan_limit = 3'd7;
    // R8: toggle blink off and back on mid-phase
    tag = "R8"; blink_frames = 8'd1; step(190);
    blink_en = 0; step(37); blink_en = 1; step(300);
    // R9: shutdown holds outputs dark while scan continues
    tag = "R9"; shutdown = 1; step(150); shutdown = 0; step(200);
    // R1: writes streaming during the scan, hitting slot loads
    tag = "R1";
    for (int c = 0; c < 700; c++) begin
      wr_en = (c % 4 == 1); wr_plane = c[3];
      wr_addr = 3'((c / 16 + 1) % 8); wr_data = 8'(c * 37 + 5);
      step(1);
    end
    wr_en = 0; step(300);
    // R10: reset mid-run clears outputs
    tag = "R10"; rst = 1; step(3); rst = 0; step(20);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule